// File: doc/BRIEF.md
# Complementary Dead-Zone Output Pair

This block turns one pulse-width-modulated source waveform into two gate-drive style outputs: a primary output that follows the source, and a complementary output that is active while the source is low. A single dead interval applies to both outputs. On every source edge, the output that must turn off does so at once. The output that must turn on waits for the programmed number of prescaled ticks. The two outputs are therefore never active together. The tick is a one-cycle enable from an external clock divider, and the dead counter advances only on ticks.

The pair runs only while the dead-zone enable is high. Clearing the enable puts the pair in a safe idle state and clears any error. A source pulse that ends before the primary's dead interval has elapsed is a configuration the pair cannot honour. The pair then latches an error, holds both outputs inactive, and stays there until the enable is cleared.

The control is a six-state machine. ST_IDLE is the state when disabled. ST_WAIT_PRI and ST_WAIT_CMP are the dead-interval waits. ST_PRI_ON and ST_CMP_ON are the driving states. ST_FAULT is the latched error state. Transitions:
- idle→wait/on: the enable is set. The source level picks the side.
- on→opposite wait: a source edge. With a dead interval of 0 the pair goes straight to the opposite on state.
- wait→on: the dead count is reached.
- ST_WAIT_CMP→ST_WAIT_PRI: the source rises early. The wait restarts.
- ST_WAIT_PRI→ST_FAULT: the source falls early.
- any state→ST_IDLE: the enable is cleared.

Top module: `dz_comp_pair`

## Requirements
- R1: After reset, and in the cycle after any edge that samples `dz_en` low, both outputs sit at their inactive level and `dz_err` is 0. Source activity has no effect while `dz_en` is low.
- R2: `pol_inv` = 0 makes both outputs active-high (inactive level 0). `pol_inv` = 1 makes both active-low (inactive level 1).
- R3: When the source is sampled high, `out_cmp` is inactive from the next cycle. Timing for `out_pri`:
  - With a tick in every cycle and a dead interval d > 0, `out_pri` becomes active on the (d+1)-th clock edge after the edge that first sampled the source high.
  - It then stays active while the source stays high.
- R4: When the source is sampled low, `out_pri` is inactive from the next cycle. `out_cmp` becomes active after the same dead wait as in R3.
- R5: With a dead interval of 0 (and no error), the outputs are exact complements and switch on the same clock edge with no gap.
- R6: The dead wait counts only cycles in which `tick` is high. The full 8-bit range up to 255 ticks is honoured.
- R7: If the source falls while the primary is still waiting out its dead interval, `dz_err` rises. Both outputs stay inactive, whatever the source does, until `dz_en` is cleared.
- R8: Clearing `dz_en` clears `dz_err` and idles both outputs in the next cycle.
- R9: A source rise while the complement is still waiting restarts the wait toward the primary and raises no error.
- R10: The primary and complementary outputs are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_src | input | 1 | Source PWM waveform, high = primary phase |
| tick | input | 1 | Prescaled count enable for the dead counter |
| dz_en | input | 1 | Dead-zone pair enable |
| dead_len | input | DEAD_W (8) | Dead interval in ticks |
| pol_inv | input | 1 | 0: outputs active-high, 1: active-low |
| out_pri | output | 1 | Primary output |
| out_cmp | output | 1 | Complementary output |
| dz_err | output | 1 | Latched error: active time shorter than dead time |

## Verification
The bench targets four corner cases:
- A primary pulse shorter than the dead interval. A design that missed it would let the primary come on late and out of phase instead of latching the error.
- A complement pulse cut short. A design that mishandled it would raise a false error, or skip the restarted wait and overlap the outputs.
- A dead interval of zero. An off-by-one here shows up as a one-cycle gap between the outputs.
- The maximum interval of 255 ticks and slow tick rates. These expose counters that wrap, or that count clocks instead of ticks.

Polarity inversion and enable drops in mid-phase are also compared against a reference model every cycle.

// File: rtl/dzp_pkg.sv
package dzp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_PRI = 3'd1,
        ST_PRI_ON   = 3'd2,
        ST_WAIT_CMP = 3'd3,
        ST_CMP_ON   = 3'd4,
        ST_FAULT    = 3'd5
    } dz_state_t;

endpackage

// File: rtl/dzp_gap_counter.sv
module dzp_gap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    assign expired = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the count only moves on a tick or a clear
    a_r6_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/dzp_level_decode.sv
module dzp_level_decode #(
    parameter int N = 2
) (
    input  logic [N-1:0] act,
    input  logic         inv,
    output logic [N-1:0] lvl
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign lvl[i] = act[i] ^ inv;
    end

endmodule

// File: rtl/dz_comp_pair.sv
module dz_comp_pair
    import dzp_pkg::*;
#(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_src,
    input  logic              tick,
    input  logic              dz_en,
    input  logic [DEAD_W-1:0] dead_len,
    input  logic              pol_inv,
    output logic              out_pri,
    output logic              out_cmp,
    output logic              dz_err
);

    localparam int LANES = 2;

    dz_state_t   state_q, state_d;
    logic        clr_cnt;
    logic        expired;
    logic        zero_gap;
    logic [LANES-1:0] act;
    logic [LANES-1:0] lvl;

    assign zero_gap = (dead_len == '0);

    dzp_gap_counter #(.W(DEAD_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_cnt),
        .tick    (tick),
        .limit   (dead_len),
        .expired (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        clr_cnt = 1'b0;
        if (!dz_en) begin
            state_d = ST_IDLE;
            clr_cnt = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    clr_cnt = 1'b1;
                    if (pwm_src) state_d = zero_gap ? ST_PRI_ON : ST_WAIT_PRI;
                    else         state_d = zero_gap ? ST_CMP_ON : ST_WAIT_CMP;
                end
                ST_PRI_ON: begin
                    if (!pwm_src) begin
                        clr_cnt = 1'b1;
                        state_d = zero_gap ? ST_CMP_ON : ST_WAIT_CMP;
                    end
                end
                ST_CMP_ON: begin
                    if (pwm_src) begin
                        clr_cnt = 1'b1;
                        state_d = zero_gap ? ST_PRI_ON : ST_WAIT_PRI;
                    end
                end
                ST_WAIT_PRI: begin
                    if (!pwm_src)    state_d = ST_FAULT;
                    else if (expired) state_d = ST_PRI_ON;
                end
                ST_WAIT_CMP: begin
                    if (pwm_src) begin
                        clr_cnt = 1'b1;
                        state_d = zero_gap ? ST_PRI_ON : ST_WAIT_PRI;
                    end else if (expired) begin
                        state_d = ST_CMP_ON;
                    end
                end
                ST_FAULT: state_d = ST_FAULT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        act[0] = (state_q == ST_PRI_ON);
        act[1] = (state_q == ST_CMP_ON);
        dz_err = (state_q == ST_FAULT);
    end

    dzp_level_decode #(.N(LANES)) u_dec (
        .act (act),
        .inv (pol_inv),
        .lvl (lvl)
    );

    assign out_pri = lvl[0];
    assign out_cmp = lvl[1];

    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dz_en |=> (out_pri == pol_inv && out_cmp == pol_inv && !dz_err));

    a_r3_cmp_off_at_once: assert property (@(posedge clk) disable iff (!rst_n)
        (dz_en && pwm_src) |=> (out_cmp == pol_inv));

    a_r4_pri_off_at_once: assert property (@(posedge clk) disable iff (!rst_n)
        (dz_en && !pwm_src) |=> (out_pri == pol_inv));

    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (dz_en && zero_gap && !dz_err && (out_pri != pol_inv || out_cmp != pol_inv))
        |=> (out_pri != out_cmp));

    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dz_err && dz_en) |=> dz_err);

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !((out_pri != pol_inv) && (out_cmp != pol_inv)));

endmodule

// File: tb/sim_dz_comp_pair.sv
`timescale 1ns/1ps
module sim_dz_comp_pair;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_src = 1'b0;
    logic       tick = 1'b1;
    logic       dz_en = 1'b0;
    logic [7:0] dead_len = 8'd0;
    logic       pol_inv = 1'b0;
    logic       out_pri, out_cmp, dz_err;

    always #2.5 clk = ~clk;

    dz_comp_pair u0 (
        .clk(clk), .rst_n(rst_n), .pwm_src(pwm_src), .tick(tick),
        .dz_en(dz_en), .dead_len(dead_len), .pol_inv(pol_inv),
        .out_pri(out_pri), .out_cmp(out_cmp), .dz_err(dz_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc_no = 0;
    int tick_div = 1;
    bit done = 0;

    // behavioural model: which side is on (0 none, 1 primary, 2 complement),
    // which side is waiting, ticks waited, latched fault
    int m_on = 0, m_pend = 0, m_wait = 0;
    bit m_fault = 0;

    always @(posedge clk or negedge rst_n) begin
        int tgt;
        if (!rst_n) begin
            m_on = 0; m_pend = 0; m_wait = 0; m_fault = 0;
        end else if (!dz_en) begin
            m_on = 0; m_pend = 0; m_wait = 0; m_fault = 0;
        end else if (!m_fault) begin
            tgt = pwm_src ? 1 : 2;
            if (m_pend == 0) begin
                if (m_on != tgt) begin
                    m_on = 0;
                    if (dead_len == 0) m_on = tgt;
                    else begin m_pend = tgt; m_wait = 0; end
                end
            end else if (m_pend != tgt) begin
                if (m_pend == 1) begin m_fault = 1; m_pend = 0; end
                else if (dead_len == 0) begin m_on = 1; m_pend = 0; end
                else begin m_pend = 1; m_wait = 0; end
            end else if (m_wait >= int'(dead_len)) begin
                m_on = m_pend; m_pend = 0;
            end else if (tick) begin
                m_wait++;
            end
        end
    end

    task automatic chk(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, what, act, exp, cyc_no);
        end
    endtask

    task automatic compare_model();
        logic ep, ec;
        ep = (m_on == 1) ? ~pol_inv : pol_inv;
        ec = (m_on == 2) ? ~pol_inv : pol_inv;
        n_chk++;
        if (out_pri !== ep || out_cmp !== ec || dz_err !== m_fault) begin
            n_bad++;
            if (out_pri !== ep)  $display("FAIL R3 out_pri: actual %b expected %b (cycle %0d)", out_pri, ep, cyc_no);
            if (out_cmp !== ec)  $display("FAIL R4 out_cmp: actual %b expected %b (cycle %0d)", out_cmp, ec, cyc_no);
            if (dz_err !== m_fault) $display("FAIL R7 dz_err: actual %b expected %b (cycle %0d)", dz_err, m_fault, cyc_no);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) compare_model();
            cyc_no++;
            tick = (tick_div <= 1) || (cyc_no % tick_div == 0);
        end
    endtask

    task automatic wave(int hi, int lo, int reps);
        for (int r = 0; r < reps; r++) begin
            pwm_src = 1'b1; step(hi);
            pwm_src = 1'b0; step(lo);
        end
    endtask

    initial begin
        int k;
        step(3);
        chk("R1", out_pri, 1'b0, "reset out_pri");
        chk("R1", out_cmp, 1'b0, "reset out_cmp");
        chk("R1", dz_err, 1'b0, "reset dz_err");
        rst_n = 1'b1;
        step(2);

        // R1: disabled pair ignores the source
        wave(3, 2, 4);
        chk("R1", out_pri, 1'b0, "disabled out_pri");
        chk("R1", out_cmp, 1'b0, "disabled out_cmp");

        // R3/R4: dead interval 3, tick every cycle
        dead_len = 8'd3; dz_en = 1'b1;
        step(20);
        chk("R4", out_cmp, 1'b1, "complement on after settle");
        pwm_src = 1'b1;
        k = 0;
        for (int i = 1; i <= 12; i++) begin
            step(1);
            if (i == 1) chk("R3", out_cmp, 1'b0, "complement off at once");
            if (k == 0 && out_pri) k = i;
        end
        // edge E0 samples the rise; active after E(d+1), seen at sample d+2
        n_chk++;
        if (k != 5) begin
            n_bad++;
            $display("FAIL R3 turn-on sample: actual %0d expected %0d", k, 5);
        end
        pwm_src = 1'b0;
        step(1);
        chk("R4", out_pri, 1'b0, "primary off at once");
        step(10);
        wave(15, 12, 3);

        // R2: inverted polarity
        pol_inv = 1'b1;
        wave(14, 14, 3);
        pwm_src = 1'b1; step(10);
        chk("R2", out_pri, 1'b0, "active-low primary active");
        chk("R2", out_cmp, 1'b1, "active-low complement idle");
        pol_inv = 1'b0;

        // R5: zero dead interval
        dead_len = 8'd0;
        step(3);
        for (int r = 0; r < 6; r++) begin
            pwm_src = ~pwm_src;
            for (int i = 0; i < 3 + r; i++) begin
                step(1);
                chk("R5", out_cmp, ~out_pri, "exact complement");
            end
        end

        // R6: slow ticks
        tick_div = 3; dead_len = 8'd5;
        wave(40, 35, 3);
        tick_div = 7;
        wave(60, 55, 2);
        tick_div = 1;

        // R6: maximum interval 255
        dead_len = 8'd255;
        pwm_src = 1'b1; step(300);
        chk("R6", out_pri, 1'b1, "primary on after 255 ticks");
        pwm_src = 1'b0; step(250);
        chk("R6", out_cmp, 1'b0, "complement still waiting");
        step(20);
        chk("R6", out_cmp, 1'b1, "complement on after 255 ticks");

        // R9: short complement pulse restarts toward primary
        dead_len = 8'd6;
        pwm_src = 1'b1; step(20);
        pwm_src = 1'b0; step(2);
        pwm_src = 1'b1; step(20);
        chk("R9", dz_err, 1'b0, "no error on short complement pulse");
        chk("R9", out_pri, 1'b1, "primary back on");

        // R7: short primary pulse
        pwm_src = 1'b0; step(20);
        pwm_src = 1'b1; step(2);
        pwm_src = 1'b0; step(2);
        chk("R7", dz_err, 1'b1, "error raised");
        wave(15, 15, 2);
        chk("R7", dz_err, 1'b1, "error held");
        chk("R7", out_pri, 1'b0, "primary idle in fault");
        chk("R7", out_cmp, 1'b0, "complement idle in fault");

        // R8: clearing the enable clears the fault
        dz_en = 1'b0; step(1);
        chk("R8", dz_err, 1'b0, "error cleared");
        dz_en = 1'b1; step(20);
        chk("R8", out_cmp, 1'b1, "restart after clear");
        pwm_src = 1'b1; step(20);
        dz_en = 1'b0; step(1);
        chk("R8", out_pri, 1'b0, "drop enable mid-phase");
        dz_en = 1'b1;
        wave(9, 11, 4);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule